// File: doc/BRIEF.md
# Mixed-Sign Multiply-Accumulate with Double-Width Result

This datapath unit multiplies an unsigned word A by a two's-complement word B. It then adds a two's-complement word C to the product. The full sum is 2×XLEN bits wide and leaves the unit as two word-sized results: a low half and a high half. The sum wraps modulo 2^(2×XLEN), and the unit reports no carry, overflow or status of any kind. The word width XLEN is a parameter with a default of 64.

The unit accepts one operation per clock, qualified by an input valid strobe. The arithmetic is combinational. A single register stage holds the results and the output valid strobe, so each result appears on the clock edge that follows the accepted input. When B is negative, the unit multiplies A by the magnitude of B and then negates the double-width product. This also covers the most negative B, whose magnitude only fits as an unsigned word. The unit is meant to be placed behind an operand-read stage. Its two result words can be written back to two destinations.

Top module: `mixmac`

## Requirements
- R1: A synchronous active-high reset drives out_valid, res_lo and res_hi to zero on the clock edge where it is sampled, and this holds even while in_valid is high.
- R2: out_valid is high in the cycle after a clock edge that sampled in_valid high with reset low, and low otherwise. Each accepted input produces exactly one result, in order.
- R3: op_a is unsigned. With op_a all ones, op_b = 1 and op_c = 0, res_hi is zero and res_lo is all ones.
- R4: op_b is two's-complement. Its top bit set means negative, and the most negative value (only bit XLEN-1 set) gives the correctly negated product.
- R5: op_c is sign-extended from its top bit to 2×XLEN bits before the addition. With op_b = 0, res_hi is XLEN copies of op_c's top bit and res_lo equals op_c.
- R6: {res_hi, res_lo} equals (unsigned(op_a) × signed(op_b) + signed(op_c)) mod 2^(2×XLEN). res_lo holds bits XLEN-1..0 and res_hi holds bits 2×XLEN-1..XLEN.
- R7: In a cycle where in_valid is low, the operand inputs are ignored, and res_lo and res_hi keep their values on the next edge.
- R8: R6 holds for every combination of op_a and op_b at XLEN = 8, with varying op_c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| op_a | input | XLEN | Unsigned multiplicand |
| op_b | input | XLEN | Signed multiplier |
| op_c | input | XLEN | Signed addend |
| out_valid | output | 1 | Results present this cycle |
| res_lo | output | XLEN | Low half of the double-width sum |
| res_hi | output | XLEN | High half of the double-width sum |

## Verification
Two events can land on one clock edge. The first is a new operation being accepted while the previous result is leaving the register stage. The second is reset being sampled while in_valid is high. The first case is provoked by streaming operands on every cycle with no gaps; the scoreboard then has to see each result exactly once, in order, with no item dropped or repeated. The second case is provoked by raising reset together with a valid operand; the result is judged correct only if out_valid and both result words read zero in the next cycle, and that operand never produces a result.

// File: rtl/mma_pkg.sv
package mma_pkg;
  localparam int unsigned DEFAULT_XLEN = 64;

  typedef enum logic {
    SIGN_POS = 1'b0,
    SIGN_NEG = 1'b1
  } sign_e;
endpackage

// File: rtl/mma_bsplit.sv
module mma_bsplit
  import mma_pkg::*;
#(
  parameter int unsigned XLEN = DEFAULT_XLEN
) (
  input  logic [XLEN-1:0] b_in,
  output logic [XLEN-1:0] b_mag,
  output sign_e           b_sgn
);
  // Magnitude of a signed word as an unsigned word; the most negative
  // value maps onto 2^(XLEN-1), which fits unsigned.
  always_comb begin
    b_sgn = b_in[XLEN-1] ? SIGN_NEG : SIGN_POS;
    b_mag = (b_sgn == SIGN_NEG) ? (~b_in + {{(XLEN-1){1'b0}}, 1'b1}) : b_in;
  end
endmodule

// File: rtl/mma_umul.sv
module mma_umul
  import mma_pkg::*;
#(
  parameter int unsigned XLEN = DEFAULT_XLEN,
  localparam int unsigned W2  = 2 * XLEN
) (
  input  logic [XLEN-1:0] a_in,
  input  logic [XLEN-1:0] m_in,
  input  sign_e           neg,
  output logic [W2-1:0]   prod
);
  logic [W2-1:0] a_w;
  logic [W2-1:0] m_w;
  logic [W2-1:0] p_u;

  always_comb begin
    a_w  = {{XLEN{1'b0}}, a_in};
    m_w  = {{XLEN{1'b0}}, m_in};
    p_u  = a_w * m_w;
    prod = (neg == SIGN_NEG) ? (~p_u + {{(W2-1){1'b0}}, 1'b1}) : p_u;
  end
endmodule

// File: rtl/mma_accum.sv
module mma_accum
  import mma_pkg::*;
#(
  parameter int unsigned XLEN = DEFAULT_XLEN,
  localparam int unsigned W2  = 2 * XLEN
) (
  input  logic [W2-1:0]   prod,
  input  logic [XLEN-1:0] c_in,
  output logic [XLEN-1:0] sum_lo,
  output logic [XLEN-1:0] sum_hi
);
  logic [W2-1:0] c_ext;
  logic [W2-1:0] total;

  always_comb begin
    c_ext  = {{XLEN{c_in[XLEN-1]}}, c_in};
    total  = prod + c_ext;
    sum_lo = total[XLEN-1:0];
    sum_hi = total[W2-1:XLEN];
  end
endmodule

// File: rtl/mixmac.sv
module mixmac
  import mma_pkg::*;
#(
  parameter int unsigned XLEN = DEFAULT_XLEN,
  localparam int unsigned W2  = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] op_c,
  output logic            out_valid,
  output logic [XLEN-1:0] res_lo,
  output logic [XLEN-1:0] res_hi
);
  logic [XLEN-1:0] b_mag;
  sign_e           b_sgn;
  logic [W2-1:0]   prod;
  logic [XLEN-1:0] nxt_lo;
  logic [XLEN-1:0] nxt_hi;

  mma_bsplit #(.XLEN(XLEN)) u_bsplit (
    .b_in  (op_b),
    .b_mag (b_mag),
    .b_sgn (b_sgn)
  );

  mma_umul #(.XLEN(XLEN)) u_umul (
    .a_in (op_a),
    .m_in (b_mag),
    .neg  (b_sgn),
    .prod (prod)
  );

  mma_accum #(.XLEN(XLEN)) u_accum (
    .prod   (prod),
    .c_in   (op_c),
    .sum_lo (nxt_lo),
    .sum_hi (nxt_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_lo    <= '0;
      res_hi    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_lo <= nxt_lo;
        res_hi <= nxt_hi;
      end
    end
  end
endmodule

// File: rtl/mixmac_chk.sv
module mixmac_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic [XLEN-1:0] op_c,
  input logic            out_valid,
  input logic [XLEN-1:0] res_lo,
  input logic [XLEN-1:0] res_hi
);
  localparam logic [XLEN-1:0] MOSTNEG = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [XLEN-1:0] ONE     = {{(XLEN-1){1'b0}}, 1'b1};

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after a sampled reset shows cleared outputs
  always_ff @(posedge clk) begin
    if (rst_q) begin
      assert_reset_clear_R1: assert (!out_valid && res_lo == '0 && res_hi == '0)
        else $error("R1 outputs not cleared after reset");
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_unsigned_a_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_b) == ONE && $past(op_c) == '0)
      |-> (res_hi == '0 && res_lo == $past(op_a)));

  assert_mostneg_b_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_b) == MOSTNEG && $past(op_a) == ONE && $past(op_c) == '0)
      |-> (res_hi == '1 && res_lo == MOSTNEG));

  assert_sext_c_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_b) == '0)
      |-> (res_hi == {XLEN{$past(op_c[XLEN-1])}} && res_lo == $past(op_c)));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_lo) && $stable(res_hi)));
endmodule

bind mixmac mixmac_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_c      (op_c),
  .out_valid (out_valid),
  .res_lo    (res_lo),
  .res_hi    (res_hi)
);

// File: tb/mixmac_tb.sv
module mixmac_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // 64-bit instance
  logic        v64 = 1'b0;
  logic [63:0] a64 = '0, b64 = '0, c64 = '0;
  logic        ov64;
  logic [63:0] lo64, hi64;

  // 8-bit instance
  logic        v8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0, c8 = '0;
  logic        ov8;
  logic [7:0]  lo8, hi8;

  mixmac #(.XLEN(64)) u_dut (
    .clk(clk), .rst(rst), .in_valid(v64), .op_a(a64), .op_b(b64), .op_c(c64),
    .out_valid(ov64), .res_lo(lo64), .res_hi(hi64)
  );

  mixmac #(.XLEN(8)) u_dut8 (
    .clk(clk), .rst(rst), .in_valid(v8), .op_a(a8), .op_b(b8), .op_c(c8),
    .out_valid(ov8), .res_lo(lo8), .res_hi(hi8)
  );

  typedef struct {
    logic [127:0] exp;
    string        tag;
  } item64_t;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item8_t;

  item64_t q64[$];
  item8_t  q8[$];
  item64_t it64;
  item8_t  it8;

  function automatic logic [127:0] ref64(logic [63:0] a, logic [63:0] b, logic [63:0] c);
    logic [129:0] ea, eb, ec, r;
    ea = {66'b0, a};
    eb = {{66{b[63]}}, b};
    ec = {{66{c[63]}}, c};
    r  = ea * eb + ec;
    return r[127:0];
  endfunction

  function automatic logic [15:0] ref8(logic [7:0] a, logic [7:0] b, logic [7:0] c);
    logic [17:0] ea, eb, ec, r;
    ea = {10'b0, a};
    eb = {{10{b[7]}}, b};
    ec = {{10{c[7]}}, c};
    r  = ea * eb + ec;
    return r[15:0];
  endfunction

  task automatic check(input bit ok, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive64(input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] c, input string tag);
    item64_t it;
    @(negedge clk);
    v64 = 1'b1; a64 = a; b64 = b; c64 = c;
    it.exp = ref64(a, b, c);
    it.tag = tag;
    q64.push_back(it);
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b,
                        input logic [7:0] c, input string tag);
    item8_t it;
    @(negedge clk);
    v8 = 1'b1; a8 = a; b8 = b; c8 = c;
    it.exp = ref8(a, b, c);
    it.tag = tag;
    q8.push_back(it);
  endtask

  // Monitors: pop and compare as results appear
  always @(negedge clk) begin
    if (!rst && ov64) begin
      if (q64.size() == 0) begin
        check(1'b0, "R2 unexpected 64-bit result", {hi64, lo64}, '0);
      end else begin
        it64 = q64.pop_front();
        check({hi64, lo64} === it64.exp, it64.tag, {hi64, lo64}, it64.exp);
      end
    end
    if (!rst && ov8) begin
      if (q8.size() == 0) begin
        check(1'b0, "R2 unexpected 8-bit result", {112'b0, hi8, lo8}, '0);
      end else begin
        it8 = q8.pop_front();
        check({hi8, lo8} === it8.exp, it8.tag, {112'b0, hi8, lo8}, {112'b0, it8.exp});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [63:0] ONES64 = '1;
  localparam logic [63:0] NEG64  = {1'b1, 63'b0};
  localparam logic [63:0] POS64  = {1'b0, {63{1'b1}}};

  initial begin
    logic [127:0] last;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(ov64 == 1'b0 && lo64 == '0 && hi64 == '0, "R1 reset state 64",
          {ov64, hi64[62:0], lo64}, '0);
    check(ov8 == 1'b0 && lo8 == '0 && hi8 == '0, "R1 reset state 8",
          {111'b0, ov8, hi8, lo8}, '0);
    rst = 1'b0;

    // Back-to-back corner stream (R2 ordering, R3..R6)
    drive64(ONES64, 64'd1, 64'd0, "R3 A all ones times one");
    drive64(ONES64, ONES64, 64'd0, "R3 A all ones times minus one");
    drive64(64'd5, NEG64, 64'd0, "R4 B most negative");
    drive64(ONES64, NEG64, ONES64, "R4 B most negative A all ones C negative");
    drive64(64'd1, NEG64, 64'd0, "R4 one times most negative");
    drive64(64'd0, 64'd7, -64'sd3, "R5 C negative A zero");
    drive64(64'd3, -64'sd2, -64'sd1, "R5 C negative B negative");
    drive64(ONES64, 64'd0, NEG64, "R5 B zero C most negative");
    drive64(ONES64, NEG64, NEG64, "R6 most negative sum");
    drive64(ONES64, POS64, POS64, "R6 largest positive sum");
    drive64(64'd12345, -64'sd678, 64'd99, "R6 mixed");
    last = ref64(64'd12345, -64'sd678, 64'd99);

    // R7: idle cycles with changing operands
    @(negedge clk);
    v64 = 1'b0; a64 = 64'hDEAD; b64 = 64'hBEEF; c64 = ONES64;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!ov64 && {hi64, lo64} == last, "R7 hold while idle",
            {hi64, lo64}, last);
      a64 = a64 + 64'd17; b64 = ~b64;
    end

    // R1 with R2 on the same edge: reset sampled while a valid operand is present
    @(negedge clk);
    rst = 1'b1; v64 = 1'b1; a64 = 64'd9; b64 = 64'd9; c64 = 64'd9;
    @(negedge clk);
    check(!ov64 && lo64 == '0 && hi64 == '0, "R1 reset beats valid",
          {ov64, hi64[62:0], lo64}, '0);
    rst = 1'b0; v64 = 1'b0;
    @(negedge clk);
    check(!ov64, "R2 dropped operand gives no result", {127'b0, ov64}, '0);

    // R8: exhaustive A x B at 8 bits, streamed every cycle
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive8(a[7:0], b[7:0], 8'(a * 7 + b * 13 + 128), "R8 exhaustive");
      end
    end
    @(negedge clk);
    v8 = 1'b0;
    repeat (3) @(negedge clk);

    check(q64.size() == 0, "R2 all 64-bit results delivered", 128'(q64.size()), '0);
    check(q8.size() == 0, "R2 all 8-bit results delivered", 128'(q8.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule